// File: doc/BRIEF.md
# Retention March Memory Self-Test Controller

This block is a built-in self-test sequencer for one single-port synchronous SRAM. A single start pulse sets off a six-step March run. The run writes a background over every word and then waits for a chosen retention time. It reads each word back and checks it. It then writes the complement of the background, waits again, and checks the complement. Both waits leave the memory quiet for a programmable number of clock cycles. Cells that lose their charge while idle are therefore seen at the following read pass.

The controller owns the memory's address, write data, write-enable and chip-enable lines. Read data is compared against the expected background one cycle after each read command, which matches the array's fixed one-cycle read latency. The first mismatch raises a sticky fail flag. It also records the failing address and the index of the step that saw it. The run always goes to the end, then pulses done and returns to idle.

The memory port is fixed-latency and has no back-pressure. Every command cycle is accepted by the array, so this block has no valid/ready stream.

Top module: `mbist_retention_ctrl`

## Requirements
- R1: After reset the controller is idle with chip-enable, write-enable, done and fail all low, and it keeps chip-enable low while idle.
- R2: A start pulse is taken only while idle. The wait length on the 24-bit retention input is captured on that same edge. Later changes to that input, and start pulses during a run, have no effect on the run.
- R3: Steps run in this order: write pass 0 (step index 0), wait 1 (index 1), read pass 0 (index 2), write pass 1 (index 3), wait 2 (index 4), read pass 1 (index 5). Passes 0 run addresses 0 up to the top address, one per cycle. Passes 1 run from the top address down to 0.
- R4: Write pass 0 drives the background (all zeros by default). Write pass 1 drives its bitwise complement. Write-enable is high only together with chip-enable.
- R5: Each wait lasts exactly the captured number of cycles, with a captured 0 counted as 1 cycle. During a wait, chip-enable and write-enable are low and the address holds the last address of the write pass before it.
- R6: Read data is compared one cycle after its read command. A mismatch sets the fail flag, which stays set until the next accepted start clears it.
- R7: The first mismatch captures its address and step index (2 or 5). Later mismatches in the same run leave them unchanged.
- R8: Done is high for exactly one cycle, two cycles after the last read command. The controller is idle in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a test run (taken only when idle) |
| ret_cycles_i | input | 24 | Wait length in clock cycles, captured at start |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_we_o | output | 1 | Memory write-enable |
| mem_ce_o | output | 1 | Memory chip-enable |
| mem_rdata_i | input | DW | Memory read data, valid one cycle after a read command |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | AW | Address of first mismatch |
| fail_elem_o | output | 3 | Step index of first mismatch |

## Verification
The assertions assume the reset is applied before any start pulse. They also assume the memory's read data follows a read command by exactly one cycle, which the bench's array model provides by construction. The stimulus changes the start and retention inputs just after a rising edge, with no glitch on them. It pulses start during runs and changes the retention value after capture, so the effect of those inputs is seen only at the ports. Faults come only from the bench's array model: stuck bits written at chosen addresses, and a cell that decays after a set idle time.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_WR0   = 4'd1,
    ST_SLP0  = 4'd2,
    ST_RD0   = 4'd3,
    ST_WR1   = 4'd4,
    ST_SLP1  = 4'd5,
    ST_RD1   = 4'd6,
    ST_FLUSH = 4'd7,
    ST_FIN   = 4'd8
  } mbist_state_e;

  localparam int ELEM_W = 3;

  // Step index reported for a state (only read passes matter for capture)
  function automatic logic [ELEM_W-1:0] step_index(mbist_state_e s);
    case (s)
      ST_WR0:  step_index = 3'd0;
      ST_SLP0: step_index = 3'd1;
      ST_RD0:  step_index = 3'd2;
      ST_WR1:  step_index = 3'd3;
      ST_SLP1: step_index = 3'd4;
      ST_RD1:  step_index = 3'd5;
      default: step_index = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_lo,
  input  logic          load_hi,
  input  logic          step_up,
  input  logic          step_dn,
  output logic [AW-1:0] addr,
  output logic          at_max,
  output logic          at_min
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load_lo) addr <= '0;
    else if (load_hi) addr <= '1;
    else if (step_up) addr <= addr + ONE;
    else if (step_dn) addr <= addr - ONE;
  end

  assign at_max = &addr;
  assign at_min = ~|addr;
endmodule

// File: rtl/mbist_ret_timer.sv
module mbist_ret_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [TW-1:0] ret_i,
  input  logic          arm,
  input  logic          run,
  output logic          expired
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] ret_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ret_q <= ONE;
    else if (capture) ret_q <= (ret_i == '0) ? ONE : ret_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (arm)                 cnt_q <= ret_q - ONE;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/mbist_fail_log.sv
module mbist_fail_log #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int EW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cmp_vld,
  input  logic [DW-1:0] cmp_exp,
  input  logic [AW-1:0] cmp_addr,
  input  logic [EW-1:0] cmp_elem,
  input  logic [DW-1:0] rdata,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [EW-1:0] fail_elem
);
  logic mismatch;
  assign mismatch = cmp_vld && (rdata != cmp_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
    end else if (clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= cmp_addr;
      fail_elem <= cmp_elem;
    end
  end
endmodule

// File: rtl/mbist_retention_ctrl.sv
module mbist_retention_ctrl
  import mbist_pkg::*;
#(
  parameter int          AW     = 8,
  parameter int          DW     = 16,
  parameter int          TW     = 24,
  parameter logic [DW-1:0] BG_PATTERN = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [TW-1:0]     ret_cycles_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_ce_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o
);
  localparam logic [DW-1:0] BG_INV = ~BG_PATTERN;

  mbist_state_e state_q, state_d;

  logic load_lo, load_hi, step_up, step_dn;
  logic at_max, at_min;
  logic tmr_capture, tmr_arm, tmr_run, tmr_expired;
  logic [AW-1:0] addr;

  // read compare pipeline stage (one-cycle memory latency)
  logic              rd_vld_q;
  logic [AW-1:0]     rd_addr_q;
  logic [DW-1:0]     rd_exp_q;
  logic [ELEM_W-1:0] rd_elem_q;

  logic is_read, is_write;
  assign is_read  = (state_q == ST_RD0) || (state_q == ST_RD1);
  assign is_write = (state_q == ST_WR0) || (state_q == ST_WR1);

  always_comb begin
    state_d     = state_q;
    load_lo     = 1'b0;
    load_hi     = 1'b0;
    step_up     = 1'b0;
    step_dn     = 1'b0;
    tmr_capture = 1'b0;
    tmr_arm     = 1'b0;
    tmr_run     = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d     = ST_WR0;
        load_lo     = 1'b1;
        tmr_capture = 1'b1;
      end
      ST_WR0: if (at_max) begin
        state_d = ST_SLP0;
        tmr_arm = 1'b1;
      end else step_up = 1'b1;
      ST_SLP0: if (tmr_expired) begin
        state_d = ST_RD0;
        load_lo = 1'b1;
      end else tmr_run = 1'b1;
      ST_RD0: if (at_max) begin
        state_d = ST_WR1;
        load_hi = 1'b1;
      end else step_up = 1'b1;
      ST_WR1: if (at_min) begin
        state_d = ST_SLP1;
        tmr_arm = 1'b1;
      end else step_dn = 1'b1;
      ST_SLP1: if (tmr_expired) begin
        state_d = ST_RD1;
        load_hi = 1'b1;
      end else tmr_run = 1'b1;
      ST_RD1: if (at_min) state_d = ST_FLUSH;
              else        step_dn = 1'b1;
      ST_FLUSH: state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  mbist_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load_lo(load_lo), .load_hi(load_hi),
    .step_up(step_up), .step_dn(step_dn),
    .addr(addr), .at_max(at_max), .at_min(at_min)
  );

  mbist_ret_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .capture(tmr_capture), .ret_i(ret_cycles_i),
    .arm(tmr_arm), .run(tmr_run), .expired(tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_addr_q <= '0;
      rd_exp_q  <= '0;
      rd_elem_q <= '0;
    end else begin
      rd_vld_q  <= is_read;
      rd_addr_q <= addr;
      rd_exp_q  <= (state_q == ST_RD0) ? BG_PATTERN : BG_INV;
      rd_elem_q <= step_index(state_q);
    end
  end

  mbist_fail_log #(.AW(AW), .DW(DW), .EW(ELEM_W)) u_log (
    .clk(clk), .rst_n(rst_n),
    .clear(tmr_capture),
    .cmp_vld(rd_vld_q), .cmp_exp(rd_exp_q),
    .cmp_addr(rd_addr_q), .cmp_elem(rd_elem_q),
    .rdata(mem_rdata_i),
    .fail(fail_o), .fail_addr(fail_addr_o), .fail_elem(fail_elem_o)
  );

  assign mem_addr_o  = addr;
  assign mem_ce_o    = is_read || is_write;
  assign mem_we_o    = is_write;
  assign mem_wdata_o = (state_q == ST_WR1) ? BG_INV : BG_PATTERN;
  assign done_o      = (state_q == ST_FIN);
endmodule

// File: rtl/mbist_retention_chk.sv
module mbist_retention_chk
  import mbist_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  mbist_state_e      state_q,
  input  logic [AW-1:0]     mem_addr_o,
  input  logic              mem_we_o,
  input  logic              mem_ce_o,
  input  logic              done_o,
  input  logic              fail_o,
  input  logic [AW-1:0]     fail_addr_o,
  input  logic [ELEM_W-1:0] fail_elem_o
);
  logic sleeping, going_up, going_dn, taking_start;
  assign sleeping     = (state_q == ST_SLP0) || (state_q == ST_SLP1);
  assign going_up     = (state_q == ST_WR0) || (state_q == ST_RD0);
  assign going_dn     = (state_q == ST_WR1) || (state_q == ST_RD1);
  assign taking_start = start_i && (state_q == ST_IDLE);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !mem_ce_o);

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (going_up && mem_addr_o != '1) |=> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (going_dn && mem_addr_o != '0) |=> (mem_addr_o == $past(mem_addr_o) - AW'(1)));

  assert_we_with_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_ce_o);

  assert_sleep_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |=> (!sleeping || ($stable(mem_addr_o) && !mem_ce_o && !mem_we_o)));

  assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !taking_start) |=> fail_o);

  assert_first_fail_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !taking_start) |=> ($stable(fail_addr_o) && $stable(fail_elem_o)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && state_q == ST_IDLE));
endmodule

bind mbist_retention_ctrl mbist_retention_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .state_q(state_q),
  .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_ce_o(mem_ce_o),
  .done_o(done_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o),
  .fail_elem_o(fail_elem_o)
);

// File: tb/mbist_retention_ctrl_tb.sv
`timescale 1ns/1ps
module mbist_retention_ctrl_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [23:0] ret_cycles_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic mem_we_o, mem_ce_o, done_o, fail_o;
  logic [DW-1:0] mem_rdata_i;
  logic [AW-1:0] fail_addr_o;
  logic [2:0] fail_elem_o;

  always #2 clk = ~clk;

  mbist_retention_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ret_cycles_i(ret_cycles_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_ce_o(mem_ce_o), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
    .fail_o(fail_o), .fail_addr_o(fail_addr_o), .fail_elem_o(fail_elem_o)
  );

  int checks = 0;
  int fails = 0;

  // ---------------- array model with fault injection ----------------
  logic [DW-1:0] mem [N];
  int wtime [N];
  int cyc = 0;
  logic sa1_en = 0; int sa1_addr = 0; int sa1_bit = 0;
  logic sa0_en = 0; int sa0_a = 0; int sa0_b = 0;
  logic dec_en = 0; int dec_addr = 0; int dec_thr = 0;

  initial for (int i = 0; i < N; i++) begin mem[i] = '0; wtime[i] = 0; end

  always @(posedge clk) begin
    logic [DW-1:0] d;
    cyc <= cyc + 1;
    if (mem_ce_o && mem_we_o) begin
      d = mem_wdata_o;
      if (sa1_en && int'(mem_addr_o) == sa1_addr) d[sa1_bit] = 1'b1;
      if (sa0_en && (int'(mem_addr_o) == sa0_a || int'(mem_addr_o) == sa0_b)) d[0] = 1'b0;
      mem[mem_addr_o] <= d;
      wtime[mem_addr_o] <= cyc;
    end else if (mem_ce_o) begin
      d = mem[mem_addr_o];
      if (dec_en && int'(mem_addr_o) == dec_addr && (cyc - wtime[mem_addr_o]) > dec_thr) d = '0;
      mem_rdata_i <= d;
    end
  end

  // ---------------- cycle reference model ----------------
  typedef struct packed {
    logic [3:0] ph;      // 0 pre, 1 wr0, 2 slp0, 3 rd0, 4 wr1, 5 slp1, 6 rd1, 7 flush, 8 fin
    logic ce;
    logic we;
    logic chk_addr;
    logic done;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
  } exp_t;

  exp_t q[$];
  logic exp_fail = 0; logic [AW-1:0] exp_faddr = '0; logic [2:0] exp_felem = '0;

  function automatic string req_of(logic [3:0] ph);
    case (ph)
      4'd1, 4'd4: return "R4";
      4'd2, 4'd5: return "R5";
      4'd3, 4'd6: return "R3";
      4'd8:       return "R8";
      default:    return "R1";
    endcase
  endfunction

  function automatic exp_t mk(logic [3:0] ph, logic ce, logic we, logic ca,
                              logic dn, int a, logic [DW-1:0] wd);
    exp_t e;
    e.ph = ph; e.ce = ce; e.we = we; e.chk_addr = ca; e.done = dn;
    e.addr = AW'(a); e.wd = wd;
    return e;
  endfunction

  task automatic build(int ret);
    int r = (ret == 0) ? 1 : ret;
    q.push_back(mk(0, 0, 0, 0, 0, 0, '0));
    for (int i = 0; i < N; i++) q.push_back(mk(1, 1, 1, 1, 0, i, 16'h0000));
    for (int i = 0; i < r; i++) q.push_back(mk(2, 0, 0, 1, 0, N-1, '0));
    for (int i = 0; i < N; i++) q.push_back(mk(3, 1, 0, 1, 0, i, '0));
    for (int i = 0; i < N; i++) q.push_back(mk(4, 1, 1, 1, 0, N-1-i, 16'hFFFF));
    for (int i = 0; i < r; i++) q.push_back(mk(5, 0, 0, 1, 0, 0, '0));
    for (int i = 0; i < N; i++) q.push_back(mk(6, 1, 0, 1, 0, N-1-i, '0));
    q.push_back(mk(7, 0, 0, 0, 0, 0, '0));
    q.push_back(mk(8, 0, 0, 0, 1, 0, '0));
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      logic bad;
      if (q.size() > 0) e = q.pop_front();
      else e = mk(0, 0, 0, 0, 0, 0, '0);
      bad = (mem_ce_o !== e.ce) || (mem_we_o !== e.we) || (done_o !== e.done)
         || (e.chk_addr && mem_addr_o !== e.addr) || (e.we && mem_wdata_o !== e.wd);
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s phase %0d: ce/we/done/addr/wdata = %b/%b/%b/%0d/%h expected %b/%b/%b/%0d/%h",
                 req_of(e.ph), e.ph, mem_ce_o, mem_we_o, done_o, mem_addr_o, mem_wdata_o,
                 e.ce, e.we, e.done, e.addr, e.wd);
      end
      if (e.done) begin
        // R6, R7: result registers at the done pulse
        checks++;
        if (fail_o !== exp_fail || (exp_fail && (fail_addr_o !== exp_faddr || fail_elem_o !== exp_felem))) begin
          fails++;
          $display("FAIL R7 fail/addr/elem = %b/%0d/%0d expected %b/%0d/%0d",
                   fail_o, fail_addr_o, fail_elem_o, exp_fail, exp_faddr, exp_felem);
        end
      end
    end
  end

  // one run; poke_mid pulses start during the run (R2)
  task automatic run(int ret, logic ef, int ea, int ee, logic poke_mid);
    exp_fail = ef; exp_faddr = AW'(ea); exp_felem = 3'(ee);
    @(posedge clk); #1;
    start_i = 1'b1; ret_cycles_i = 24'(ret);
    build(ret);
    @(posedge clk); #1;
    start_i = 1'b0; ret_cycles_i = 24'hABCDE;   // R2: changing after capture is ignored
    @(negedge clk);
    checks++;                                   // R6: accepted start clears fail
    if (fail_o !== 1'b0) begin
      fails++;
      $display("FAIL R6 fail_o after start = %b expected 0", fail_o);
    end
    if (poke_mid) begin
      repeat (20) @(posedge clk);
      #1 start_i = 1'b1; ret_cycles_i = 24'd2;  // R2: start while busy ignored
      @(posedge clk); #1 start_i = 1'b0;
    end
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;                                   // R1: reset state
    if (mem_ce_o !== 0 || mem_we_o !== 0 || done_o !== 0 || fail_o !== 0) begin
      fails++;
      $display("FAIL R1 reset ce/we/done/fail = %b/%b/%b/%b expected 0/0/0/0",
               mem_ce_o, mem_we_o, done_o, fail_o);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run(0, 0, 0, 0, 0);                          // R5: zero wait counts as one cycle
    run(1, 0, 0, 0, 0);
    sa1_en = 1; sa1_addr = 5; sa1_bit = 3;
    run(7, 1, 5, 2, 1);                          // R6: sticky through pass 1; R2 poke
    sa1_en = 0;
    sa0_en = 1; sa0_a = 3; sa0_b = 9;
    run(3, 1, 9, 5, 0);                          // R7: descending pass meets 9 first
    sa0_en = 0;
    dec_en = 1; dec_addr = 40; dec_thr = N + 100;
    run(5, 0, 0, 0, 0);                          // short wait: cell holds
    run(300, 1, 40, 5, 0);                       // R5: long wait exposes decay
    dec_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired, actual hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule